// File: doc/BRIEF.md
# Debounced Lift Floor Tracker

This block turns the raw infrared beam-break bits of a lift shaft into a steady floor number. There is one sensor bit per floor position. A bit reads 1 while the car blocks that beam. Each bit first passes through a short sampling register. That register only advances on a slow enable tick, which comes from a shared free-running counter outside the block.

A debounced bit flips only after every sampling stage holds the same value. The tracker then combines the debounced bits with the motor status (running or asleep, up or down) to choose the floor it reports. Sensor bit i stands for floor i+1.

Blind spots read all zero, and the tracker keeps its last floor through them. It also accepts two adjacent bits being set at once, which happens when the car sits between two sensors. It outputs a binary floor number and an at-floor flag. A motor controller uses the flag to decide when to stop.

Top module: `lift_floor_tracker`

## Requirements
- R1: After reset `floor_num` is 1 and `at_floor` is 0, and `floor_num` always stays within 1 to NUM_SENSORS.
- R2: A raw bit that holds its value across three ticks changes the debounced bit one clock after the third tick, and `floor_num` follows one clock later.
- R3: A raw value held for fewer than three consecutive ticks does not change the debounced bit, so the floor and the flag are unaffected.
- R4: When all debounced bits are 0 (blind spot), `floor_num` keeps its value.
- R5: With `motor_on`=1 and `motor_down`=0 (moving up), the floor becomes the highest set debounced bit index plus one, if that is above the present floor.
- R6: With `motor_on`=1 and `motor_down`=1 (moving down), the floor becomes the lowest set debounced bit index plus one, if that is below the present floor.
- R7: Bits that lie against the direction of travel are ignored: moving up never lowers the floor, and moving down never raises it.
- R8: With `motor_on`=0 (idle), the floor holds if the bit of the present floor is set. Otherwise it becomes the lowest set bit index plus one.
- R9: `at_floor` equals the debounced bit at index `floor_num`-1.
- R10: Two adjacent set bits are accepted as a floor reading. Moving up takes the upper one, moving down takes the lower one, and idle keeps the present floor when it is one of them.
- R11: While `deb_tick` is 0, changes on `sensor_raw` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| deb_tick | input | 1 | Single-cycle debounce pacing tick from a divided counter bit |
| sensor_raw | input | NUM_SENSORS | Raw beam-break bits, 1 = beam cut |
| motor_on | input | 1 | 1 = motor running, 0 = asleep |
| motor_down | input | 1 | Direction: 1 = down, 0 = up |
| floor_num | output | FLOOR_W | Current floor, binary, 1-based |
| at_floor | output | 1 | Debounced bit of the held floor |

## Verification
A change on a sensor needs three ticks to pass the debounce. The debounced bit moves on the clock after the third tick, and `floor_num` and `at_floor` settle on the clock after that. That makes two clocks of latency after the third tick. The bench checks this exact cycle once: the floor must still be the old value one clock after the third tick and must hold the new value one clock later. Every other check waits three clocks after the third tick and samples on the falling edge, so each check starts from a known, settled state. The sweep covers every start floor, every motor mode and every sensor pattern.

// File: rtl/lift_pkg.sv
package lift_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2
  } motor_mode_e;

  function automatic motor_mode_e decode_mode(input logic on, input logic down);
    if (!on)  return MODE_IDLE;
    if (down) return MODE_DOWN;
    return MODE_UP;
  endfunction
endpackage

// File: rtl/sensor_debounce.sv
module sensor_debounce #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic clean
);
  logic [DEPTH-1:0] stage_q;
  logic             clean_q;
  logic             all_one;
  logic             all_zero;

  assign all_one  = &stage_q;
  assign all_zero = ~|stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (tick) begin
      stage_q <= {stage_q[DEPTH-2:0], raw};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean_q <= 1'b0;
    end else if (all_one) begin
      clean_q <= 1'b1;
    end else if (all_zero) begin
      clean_q <= 1'b0;
    end
  end

  assign clean = clean_q;

  // R3: mixed stages leave the clean bit untouched
  assert_mixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_one && !all_zero) |=> $stable(clean_q));

  // R11: no tick, no sampling
  assert_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(stage_q));
endmodule

// File: rtl/floor_resolver.sv
module floor_resolver
  import lift_pkg::*;
#(
  parameter int NUM_SENSORS = 5,
  parameter int FLOOR_W     = $clog2(NUM_SENSORS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SENSORS-1:0] clean,
  input  logic                   motor_on,
  input  logic                   motor_down,
  output logic [FLOOR_W-1:0]     floor_num,
  output logic                   at_floor
);
  localparam logic [FLOOR_W-1:0] FLOOR_FIRST = FLOOR_W'(1);
  localparam logic [FLOOR_W-1:0] FLOOR_LAST  = FLOOR_W'(NUM_SENSORS);

  // highest set bit as 1-based floor, 0 when none
  function automatic logic [FLOOR_W-1:0] top_floor(input logic [NUM_SENSORS-1:0] v);
    logic [FLOOR_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SENSORS; i++) if (v[i]) r = FLOOR_W'(i + 1);
    return r;
  endfunction

  // lowest set bit as 1-based floor, 0 when none
  function automatic logic [FLOOR_W-1:0] bottom_floor(input logic [NUM_SENSORS-1:0] v);
    logic [FLOOR_W-1:0] r;
    r = '0;
    for (int i = NUM_SENSORS - 1; i >= 0; i--) if (v[i]) r = FLOOR_W'(i + 1);
    return r;
  endfunction

  function automatic logic bit_of_floor(input logic [NUM_SENSORS-1:0] v,
                                        input logic [FLOOR_W-1:0] f);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_SENSORS; i++) if (f == FLOOR_W'(i + 1)) r = v[i];
    return r;
  endfunction

  motor_mode_e        mode;
  logic [FLOOR_W-1:0] floor_q;
  logic [FLOOR_W-1:0] floor_d;
  logic [FLOOR_W-1:0] up_cand;
  logic [FLOOR_W-1:0] dn_cand;
  logic               blind;
  logic               here_set;
  logic               step_up;
  logic               step_down;

  assign mode     = decode_mode(motor_on, motor_down);
  assign blind    = ~|clean;
  assign up_cand  = top_floor(clean);
  assign dn_cand  = bottom_floor(clean);
  assign here_set = bit_of_floor(clean, floor_q);
  assign step_up   = !blind && (mode == MODE_UP)   && (up_cand > floor_q);
  assign step_down = !blind && (mode == MODE_DOWN) && (dn_cand < floor_q);

  always_comb begin
    floor_d = floor_q;
    if (!blind) begin
      unique case (mode)
        MODE_UP:   if (step_up)   floor_d = up_cand;
        MODE_DOWN: if (step_down) floor_d = dn_cand;
        default:   if (!here_set) floor_d = dn_cand;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) floor_q <= FLOOR_FIRST;
    else        floor_q <= floor_d;
  end

  assign floor_num = floor_q;
  assign at_floor  = here_set;

  assert_floor_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (floor_q >= FLOOR_FIRST) && (floor_q <= FLOOR_LAST));

  assert_blind_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blind |=> $stable(floor_q));

  assert_up_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UP) |=> (floor_q >= $past(floor_q)));

  assert_down_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DOWN) |=> (floor_q <= $past(floor_q)));

  assert_step_up_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |=> (floor_q == $past(up_cand)));

  assert_step_down_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_down |=> (floor_q == $past(dn_cand)));
endmodule

// File: rtl/lift_floor_tracker.sv
module lift_floor_tracker #(
  parameter int NUM_SENSORS = 5,
  parameter int DEB_DEPTH   = 3,
  parameter int FLOOR_W     = $clog2(NUM_SENSORS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   deb_tick,
  input  logic [NUM_SENSORS-1:0] sensor_raw,
  input  logic                   motor_on,
  input  logic                   motor_down,
  output logic [FLOOR_W-1:0]     floor_num,
  output logic                   at_floor
);
  logic [NUM_SENSORS-1:0] clean_bits;

  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_deb
    sensor_debounce #(.DEPTH(DEB_DEPTH)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (deb_tick),
      .raw   (sensor_raw[g]),
      .clean (clean_bits[g])
    );
  end

  floor_resolver #(
    .NUM_SENSORS (NUM_SENSORS),
    .FLOOR_W     (FLOOR_W)
  ) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .clean      (clean_bits),
    .motor_on   (motor_on),
    .motor_down (motor_down),
    .floor_num  (floor_num),
    .at_floor   (at_floor)
  );
endmodule

// File: tb/sim_lift_floor_tracker.sv
module sim_lift_floor_tracker;
  localparam int N  = 5;
  localparam int FW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          deb_tick = 1'b0;
  logic [N-1:0]  sensor_raw = '0;
  logic          motor_on = 1'b0;
  logic          motor_down = 1'b0;
  logic [FW-1:0] floor_num;
  logic          at_floor;

  int checks = 0;
  int errors = 0;
  int model_floor = 1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lift_floor_tracker #(.NUM_SENSORS(N), .DEB_DEPTH(3)) u0 (
    .clk(clk), .rst_n(rst_n), .deb_tick(deb_tick), .sensor_raw(sensor_raw),
    .motor_on(motor_on), .motor_down(motor_down),
    .floor_num(floor_num), .at_floor(at_floor)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) deb_tick = 1'b1;
    @(negedge clk) deb_tick = 1'b0;
  endtask

  // reference: floor from pattern, start floor and mode, by arithmetic scan
  function automatic int ref_floor(int cur, int pat, bit on, bit down);
    int hi = 0, lo = 0;
    if (pat == 0) return cur;
    for (int k = 1; k <= N; k++) if ((pat >> (k - 1)) % 2 == 1) hi = k;
    for (int k = N; k >= 1; k--) if ((pat >> (k - 1)) % 2 == 1) lo = k;
    if (!on) return ((pat >> (cur - 1)) % 2 == 1) ? cur : lo;
    if (!down) return (hi > cur) ? hi : cur;
    return (lo < cur) ? lo : cur;
  endfunction

  task automatic apply(input int pat, input bit on, input bit down);
    @(negedge clk);
    sensor_raw = N'(pat);
    motor_on = on;
    motor_down = down;
    repeat (3) tick_once();
    repeat (3) @(negedge clk);
    model_floor = ref_floor(model_floor, pat, on, down);
  endtask

  function automatic bit adjacent_pair(int pat);
    for (int k = 0; k < N - 1; k++) if (pat == (3 << k)) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset floor", int'(floor_num), 1);
    check("R1 reset at_floor", int'(at_floor), 0);
    rst_n = 1'b1;

    // R2: exact latency of a sensor change, idle, bit1 -> floor 2
    @(negedge clk) sensor_raw = 5'b00010;
    tick_once();
    tick_once();
    check("R2 after two ticks", int'(floor_num), 1);
    tick_once();
    check("R2 on third tick", int'(floor_num), 1);
    @(negedge clk);
    check("R2 one clock later floor", int'(floor_num), 1);
    check("R2 one clock later flag", int'(at_floor), 0);
    @(negedge clk);
    check("R2 two clocks later floor", int'(floor_num), 2);
    check("R2 two clocks later flag", int'(at_floor), 1);
    model_floor = 2;

    // R11: raw changes without ticks
    @(negedge clk) sensor_raw = 5'b01000;
    repeat (20) @(negedge clk);
    check("R11 no tick floor", int'(floor_num), 2);
    check("R11 no tick flag", int'(at_floor), 1);

    // R3: glitch for two ticks then back
    @(negedge clk) sensor_raw = 5'b01000;
    tick_once();
    tick_once();
    @(negedge clk) sensor_raw = 5'b00010;
    repeat (3) tick_once();
    repeat (3) @(negedge clk);
    check("R3 glitch floor", int'(floor_num), 2);
    check("R3 glitch flag", int'(at_floor), 1);

    // R4: blind spot while moving up
    apply(0, 1'b1, 1'b0);
    check("R4 blind floor", int'(floor_num), 2);
    check("R4 blind flag", int'(at_floor), 0);

    // sweep: every start floor, mode, pattern
    for (int start = 1; start <= N; start++) begin
      for (int m = 0; m < 3; m++) begin
        for (int pat = 0; pat < (1 << N); pat++) begin
          string tag;
          bit on;
          bit down;
          apply(1 << (start - 1), 1'b0, 1'b0);
          check("R8 set start floor", int'(floor_num), start);
          on = (m != 0);
          down = (m == 2);
          apply(pat, on, down);
          if (pat == 0) tag = "R4 blind hold";
          else if (adjacent_pair(pat)) tag = "R10 adjacent pair";
          else if (m == 0) tag = "R8 idle";
          else if (m == 1) tag = (pat < (1 << start)) ? "R7 against up" : "R5 up";
          else tag = ((pat >> (start - 1)) == 0) ? "R6 down" :
                     ((pat % (1 << (start - 1))) == 0 ? "R7 against down" : "R6 down");
          check(tag, int'(floor_num), model_floor);
          check("R9 at_floor", int'(at_floor), (pat >> (model_floor - 1)) % 2);
          check("R1 range", int'(floor_num >= 1 && floor_num <= N), 1);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule